// File: doc/BRIEF.md
# Flash Write-Status Reporting Engine

This block produces the status word that a parallel NOR flash returns on reads while an internal program or erase operation is running. It receives already-decoded command events (program, sector erase, chip erase, erase suspend, erase resume, reset), a read strobe with its address, and the array data that a plain read would return. It drives an 8-bit read data bus and a ready/busy flag. While busy, the data bus carries polling, toggle, failure and erase-timer bits in place of array data.

Program and erase durations, the sector-erase acceptance window and the program pulse limit are parameters counted in clock cycles. A program that tries to raise any bit from 0 to 1 never completes. Once the pulse limit is reached it reports a failure, and it stays in that state until a reset command arrives. Sector erase commands build up a selection mask while the acceptance window is open. A chip erase starts at once. An erase can be suspended, so that the other sectors can be read or programmed, and then resumed.

Top module: `flash_status_engine`

## Requirements
- R1: After reset, and whenever no operation is active, `ready_o`=1 and `dout_o` equals `array_data_i`. Commands are encoded on `cmd_op_i` as 0 none, 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume, 6 reset. Suspend, resume and reset have no effect when the block is idle.
- R2: A legal program keeps `ready_o`=0 for PGM_CYC cycles and then returns to array reads. During the program the status word is bit7 = inverse of bit 7 of the program data, bit6 = a toggle that flips after every read strobe, bit5 = 0, bit2 = held (no flip), and bits 4, 3, 1, 0 = 0.
- R3: A program whose data has a 1 where `cell_data_i` has a 0 runs for PGM_LIM cycles. After that, bit5 reads 1 and `ready_o` stays 0, and bits 7 and 6 behave as in R2. Only a reset command returns the block to array reads.
- R4: A sector erase (sector = top log2(NUM_SECT) address bits) opens a window of WIN_CYC cycles. During the window bit3=0, bit7=0 and `ready_o`=0. Each further sector erase inside the window adds its sector and restarts the full window.
- R5: When the window expires the erase runs for ERS_CYC cycles with bit3=1, bit7=0 and bit6 flipping on every read. Bit2 flips only on reads whose address lies in a selected sector. When the erase ends, the block returns to array reads.
- R6: While a program or an erase is running, every command except suspend (in erase) is ignored.
- R7: A chip erase skips the window: bit3=1 from the next cycle, and all sectors are selected.
- R8: Suspend during the erase phase sets `ready_o`=1. A read inside a selected sector returns bit7=1, bit6 steady and bit2 flipping. A read outside the selected sectors returns array data. Resume continues the erase with its remaining cycle count.
- R9: While suspended, a program to an unselected sector runs as in R2 (`ready_o`=0, bit6 flipping) and then returns to the suspended state. A program to a selected sector is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Decoded command present this cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | ADDR_W | Command target address |
| cmd_data_i | input | 8 | Program data |
| cell_data_i | input | 8 | Current cell content at the program address |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Array content at the read address |
| dout_o | output | 8 | Read data or status word |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench covers a legal program, an illegal program that must time out, a sector erase extended by a second sector inside the window, a chip erase, and a suspend that carries an erase-suspend program. Together these separate polling from toggling and window from running erase. Reads alternate between selected and unselected sectors, which exposes a bit2 that flips on the wrong address, and steady versus flipping bit6 across suspend. Commands issued during busy phases, including a program aimed at a suspended sector, confirm through later reads that no state changed.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PGM = 3'd1, OP_SERASE = 3'd2, OP_CERASE = 3'd3,
    OP_SUSPEND = 3'd4, OP_RESUME = 3'd5, OP_RESET = 3'd6, OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PGM, ST_FAIL, ST_WIN, ST_ERS, ST_SUSP, ST_SPGM
  } st_e;
endpackage

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_SECT = 8,
  parameter int WIN_CYC  = 2500,
  parameter int ERS_CYC  = 5000,
  parameter int PGM_CYC  = 10,
  parameter int PGM_LIM  = 100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [7:0]          cmd_data_i,
  input  logic [7:0]          cell_data_i,
  output st_e                 st_o,
  output logic [NUM_SECT-1:0] mask_o,
  output logic                b7_o
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int EMAX   = (WIN_CYC > ERS_CYC) ? WIN_CYC : ERS_CYC;
  localparam int EC_W   = $clog2(EMAX) + 1;
  localparam int PC_W   = $clog2(PGM_LIM) + 1;

  st_e                 st_q, st_d;
  logic [NUM_SECT-1:0] mask_q, mask_d, smask;
  logic [EC_W-1:0]     ec_q, ec_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic                bad_q, bad_d, b7_q, b7_d;
  op_e                 op;
  logic                is_op;

  assign op    = op_e'(cmd_op_i);
  assign smask = NUM_SECT'(1) << cmd_addr_i[ADDR_W-1 -: SECT_W];

  function automatic logic cmd_is(logic v, op_e o, op_e want);
    return v && (o == want);
  endfunction

  always_comb begin
    st_d = st_q; mask_d = mask_q; ec_d = ec_q; pc_d = pc_q;
    bad_d = bad_q; b7_d = b7_q;
    is_op = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_is(cmd_valid_i, op, OP_PGM)) begin
          st_d = ST_PGM; pc_d = '0; bad_d = |(cmd_data_i & ~cell_data_i);
          b7_d = cmd_data_i[7];
        end else if (cmd_is(cmd_valid_i, op, OP_SERASE)) begin
          st_d = ST_WIN; mask_d = smask; ec_d = '0;
        end else if (cmd_is(cmd_valid_i, op, OP_CERASE)) begin
          st_d = ST_ERS; mask_d = '1; ec_d = '0;
        end
      end
      ST_PGM, ST_SPGM: begin
        is_op = 1'b1;
        pc_d  = pc_q + 1'b1;
        if (!bad_q && pc_q == PC_W'(PGM_CYC - 1))
          st_d = (st_q == ST_SPGM) ? ST_SUSP : ST_IDLE;
        else if (bad_q && pc_q == PC_W'(PGM_LIM - 1))
          st_d = ST_FAIL;
      end
      ST_FAIL: begin
        if (cmd_is(cmd_valid_i, op, OP_RESET)) begin
          st_d = ST_IDLE; mask_d = '0;
        end
      end
      ST_WIN: begin
        if (cmd_is(cmd_valid_i, op, OP_SERASE)) begin
          mask_d = mask_q | smask; ec_d = '0;  // restart full window
        end else if (ec_q == EC_W'(WIN_CYC - 1)) begin
          st_d = ST_ERS; ec_d = '0;
        end else ec_d = ec_q + 1'b1;
      end
      ST_ERS: begin
        if (cmd_is(cmd_valid_i, op, OP_SUSPEND)) st_d = ST_SUSP;
        else if (ec_q == EC_W'(ERS_CYC - 1)) begin
          st_d = ST_IDLE; mask_d = '0;
        end else ec_d = ec_q + 1'b1;
      end
      ST_SUSP: begin
        if (cmd_is(cmd_valid_i, op, OP_RESUME)) st_d = ST_ERS;
        else if (cmd_is(cmd_valid_i, op, OP_PGM) && !(|(mask_q & smask))) begin
          st_d = ST_SPGM; pc_d = '0; bad_d = |(cmd_data_i & ~cell_data_i);
          b7_d = cmd_data_i[7];
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mask_q <= '0; ec_q <= '0; pc_q <= '0;
      bad_q <= 1'b0; b7_q <= 1'b0;
    end else begin
      st_q <= st_d; mask_q <= mask_d; ec_q <= ec_d; pc_q <= pc_d;
      bad_q <= bad_d; b7_q <= b7_d;
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
  assign b7_o   = b7_q;
endmodule

// File: rtl/fse_toggle.sv
module fse_toggle
  import fse_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  st_e  st_i,
  input  logic hit_i,
  output logic tog6_o,
  output logic tog2_o
);
  logic flip6, flip2;

  assign flip6 = rd_i && (st_i inside {ST_PGM, ST_SPGM, ST_FAIL, ST_WIN, ST_ERS});
  assign flip2 = rd_i && hit_i && (st_i inside {ST_WIN, ST_ERS, ST_SUSP});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog6_o <= 1'b0; tog2_o <= 1'b0;
    end else begin
      if (flip6) tog6_o <= ~tog6_o;
      if (flip2) tog2_o <= ~tog2_o;
    end
  end
endmodule

// File: rtl/fse_status_mux.sv
module fse_status_mux
  import fse_pkg::*;
(
  input  st_e        st_i,
  input  logic       hit_i,
  input  logic       b7_i,
  input  logic       tog6_i,
  input  logic       tog2_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] dout_o,
  output logic       ready_o
);
  always_comb begin
    dout_o  = array_data_i;
    ready_o = 1'b1;
    unique case (st_i)
      ST_PGM, ST_SPGM: begin dout_o = {~b7_i, tog6_i, 3'b000, tog2_i, 2'b00}; ready_o = 1'b0; end
      ST_FAIL: begin dout_o = {~b7_i, tog6_i, 3'b100, tog2_i, 2'b00}; ready_o = 1'b0; end
      ST_WIN:  begin dout_o = {1'b0, tog6_i, 3'b000, tog2_i, 2'b00}; ready_o = 1'b0; end
      ST_ERS:  begin dout_o = {1'b0, tog6_i, 3'b001, tog2_i, 2'b00}; ready_o = 1'b0; end
      ST_SUSP: if (hit_i) dout_o = {1'b1, tog6_i, 3'b000, tog2_i, 2'b00};
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_SECT = 8,
  parameter int WIN_CYC  = 2500,
  parameter int ERS_CYC  = 5000,
  parameter int PGM_CYC  = 10,
  parameter int PGM_LIM  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  input  logic [7:0]        cell_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        dout_o,
  output logic              ready_o
);
  localparam int SECT_W = $clog2(NUM_SECT);

  st_e                 st;
  logic [NUM_SECT-1:0] sel_mask;
  logic                b7, tog6, tog2, hit;

  assign hit = sel_mask[rd_addr_i[ADDR_W-1 -: SECT_W]];

  fse_seq #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .WIN_CYC(WIN_CYC),
    .ERS_CYC(ERS_CYC), .PGM_CYC(PGM_CYC), .PGM_LIM(PGM_LIM)
  ) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_data_i,
    .cell_data_i, .st_o(st), .mask_o(sel_mask), .b7_o(b7)
  );

  fse_toggle u_tog (
    .clk_i, .rst_ni, .rd_i, .st_i(st), .hit_i(hit), .tog6_o(tog6), .tog2_o(tog2)
  );

  fse_status_mux u_mux (
    .st_i(st), .hit_i(hit), .b7_i(b7), .tog6_i(tog6), .tog2_i(tog2),
    .array_data_i, .dout_o, .ready_o
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker
  import fse_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_op_i,
  input logic       rd_i,
  input logic       ready_o,
  input logic [7:0] dout_o,
  input st_e        st,
  input logic       tog6
);
  p_fail_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FAIL) |-> (!ready_o && dout_o[5]));

  p_win_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WIN && cmd_valid_i && cmd_op_i == 3'd2) |=> (st == ST_WIN));

  p_erase_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ERS && cmd_valid_i && cmd_op_i != 3'd4) |=> (st == ST_ERS || st == ST_IDLE));

  p_chip_nowin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && cmd_valid_i && cmd_op_i == 3'd3) |=> (st == ST_ERS));

  p_tog6_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PGM && rd_i) |=> (tog6 != $past(tog6)));

  p_susp_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUSP && rd_i) |=> $stable(tog6));
endmodule

bind flash_status_engine fse_checker u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .rd_i, .ready_o, .dout_o,
  .st(st), .tog6(tog6)
);

// File: tb/flash_status_engine_tb.sv
`timescale 1ns/1ps
module flash_status_engine_tb;
  localparam int AW = 8, NS = 8, WIN = 12, ERS = 30, PGC = 5, LIM = 20;
  localparam int S_IDLE = 0, S_PGM = 1, S_FAIL = 2, S_WIN = 3, S_ERS = 4, S_SUSP = 5, S_SPGM = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rd = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, cell_data = 8'hFF, array_data, dout;
  logic ready;
  int errors = 0, checks = 0;
  string phase_tag = "";

  assign array_data = rd_addr ^ 8'h3C;
  always #10 clk = ~clk;

  flash_status_engine #(.ADDR_W(AW), .NUM_SECT(NS), .WIN_CYC(WIN), .ERS_CYC(ERS),
    .PGM_CYC(PGC), .PGM_LIM(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cell_data_i(cell_data),
    .rd_i(rd), .rd_addr_i(rd_addr), .array_data_i(array_data),
    .dout_o(dout), .ready_o(ready));

  // behavioural reference
  int m_st = S_IDLE, m_ec = 0, m_pc = 0;
  bit [NS-1:0] m_mask = '0;
  bit m_bad = 0, m_b7 = 0, m_t6 = 0, m_t2 = 0, m_chip = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_IDLE; m_ec = 0; m_pc = 0; m_mask = '0; m_bad = 0; m_b7 = 0;
      m_t6 = 0; m_t2 = 0; m_chip = 0;
    end else begin
      bit h;
      int sct;
      h = m_mask[rd_addr[7:5]];
      sct = int'(cmd_addr[7:5]);
      if (rd && (m_st == S_PGM || m_st == S_SPGM || m_st == S_FAIL || m_st == S_WIN || m_st == S_ERS)) m_t6 = !m_t6;
      if (rd && h && (m_st == S_WIN || m_st == S_ERS || m_st == S_SUSP)) m_t2 = !m_t2;
      case (m_st)
        S_IDLE: if (cmd_valid) begin
          if (cmd_op == 1) begin m_st = S_PGM; m_pc = 0; m_bad = (cmd_data & ~cell_data) != 0; m_b7 = cmd_data[7]; end
          else if (cmd_op == 2) begin m_st = S_WIN; m_mask = '0; m_mask[sct] = 1; m_ec = 0; m_chip = 0; end
          else if (cmd_op == 3) begin m_st = S_ERS; m_mask = '1; m_ec = 0; m_chip = 1; end
        end
        S_PGM, S_SPGM: begin
          m_pc++;
          if (!m_bad && m_pc == PGC) m_st = (m_st == S_SPGM) ? S_SUSP : S_IDLE;
          else if (m_bad && m_pc == LIM) m_st = S_FAIL;
        end
        S_FAIL: if (cmd_valid && cmd_op == 6) begin m_st = S_IDLE; m_mask = '0; end
        S_WIN: if (cmd_valid && cmd_op == 2) begin m_mask[sct] = 1; m_ec = 0; end
               else begin m_ec++; if (m_ec == WIN) begin m_st = S_ERS; m_ec = 0; end end
        S_ERS: if (cmd_valid && cmd_op == 4) m_st = S_SUSP;
               else begin m_ec++; if (m_ec == ERS) begin m_st = S_IDLE; m_mask = '0; end end
        S_SUSP: if (cmd_valid && cmd_op == 5) m_st = S_ERS;
                else if (cmd_valid && cmd_op == 1 && !m_mask[sct]) begin
                  m_st = S_SPGM; m_pc = 0; m_bad = (cmd_data & ~cell_data) != 0; m_b7 = cmd_data[7];
                end
        default: ;
      endcase
    end
  end

  function automatic string tag_of(int s);
    case (s)
      S_PGM: return "R2";  S_FAIL: return "R3"; S_WIN: return "R4";
      S_ERS: return m_chip ? "R7" : "R5";
      S_SUSP: return "R8"; S_SPGM: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ready,dout} actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [7:0] e; logic er; bit h;
    h = m_mask[rd_addr[7:5]];
    e = array_data; er = 1;
    case (m_st)
      S_PGM, S_SPGM: begin e = {~m_b7, m_t6, 3'b000, m_t2, 2'b00}; er = 0; end
      S_FAIL: begin e = {~m_b7, m_t6, 3'b100, m_t2, 2'b00}; er = 0; end
      S_WIN:  begin e = {1'b0, m_t6, 3'b000, m_t2, 2'b00}; er = 0; end
      S_ERS:  begin e = {1'b0, m_t6, 3'b001, m_t2, 2'b00}; er = 0; end
      S_SUSP: if (h) e = {1'b1, m_t6, 3'b000, m_t2, 2'b00};
      default: ;
    endcase
    check(phase_tag != "" ? phase_tag : tag_of(m_st), {ready, dout}, {er, e});
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd(int op, logic [7:0] a, logic [7:0] d, logic [7:0] c);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d; cell_data = c;
    tick(1);
    cmd_valid = 0; cmd_op = '0;
  endtask

  task automatic rd_at(logic [7:0] a, int n);
    rd_addr = a;
    for (int i = 0; i < n; i++) begin rd = 1; tick(1); end
    rd = 0;
  endtask

  initial begin
    #(200_000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    tick(1);
    // R1: reset state and idle-ignored commands
    @(negedge clk) check("R1", {ready, dout}, {1'b1, array_data});
    tick(1);
    cmd(4, 8'h00, 8'h00, 8'hFF); cmd(5, 8'h00, 8'h00, 8'hFF); cmd(6, 8'h00, 8'h00, 8'hFF);
    rd_at(8'h12, 2);
    // R2: legal program
    cmd(1, 8'h10, 8'hA5, 8'hFF);
    rd_at(8'h10, 3); tick(4);
    // R3: illegal program then reset
    cmd(1, 8'h20, 8'h0F, 8'hF0);
    phase_tag = "R6"; cmd(2, 8'h40, 8'h00, 8'hFF); phase_tag = "";
    rd_at(8'h20, 4); tick(LIM);
    @(negedge clk) check("R3", {ready, dout[5]}, {1'b0, 1'b1});
    tick(1);
    rd_at(8'h20, 2);
    cmd(1, 8'h20, 8'h00, 8'hFF);  // ignored in fail
    cmd(6, 8'h00, 8'h00, 8'hFF);
    tick(2);
    // R4/R5: sector erase, extend with second sector
    cmd(2, 8'h40, 8'h00, 8'hFF);
    rd_at(8'h44, 2); rd_at(8'hA4, 2); tick(WIN - 6);
    cmd(2, 8'hA0, 8'h00, 8'hFF);
    rd_at(8'hA4, 3); tick(WIN - 2);
    rd_at(8'h44, 3); rd_at(8'h04, 3);
    // R6: ignored commands during erase
    phase_tag = "R6";
    cmd(1, 8'h04, 8'h00, 8'hFF); cmd(2, 8'h04, 8'h00, 8'hFF); cmd(3, 8'h00, 8'h00, 8'hFF);
    rd_at(8'h04, 2);
    phase_tag = "";
    // R8: suspend
    cmd(4, 8'h00, 8'h00, 8'hFF);
    rd_at(8'h48, 3); rd_at(8'hA8, 1); rd_at(8'h08, 2);
    // R9: program in suspend
    cmd(1, 8'h48, 8'h00, 8'hFF);  // suspended sector: ignored
    rd_at(8'h48, 1);
    cmd(1, 8'hE1, 8'h3C, 8'hFF);
    rd_at(8'hE1, 3); tick(PGC);
    rd_at(8'hE1, 1); rd_at(8'h48, 1);
    cmd(5, 8'h00, 8'h00, 8'hFF);
    rd_at(8'h48, 2); tick(ERS);
    // R7: chip erase
    cmd(3, 8'h00, 8'h00, 8'hFF);
    rd_at(8'h04, 3); rd_at(8'hE4, 2); tick(ERS + 2);
    rd_at(8'h30, 2);
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule